// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt events from two groups of edge-triggered sources and reduces them to one CPU interrupt line. A secondary group of eight sources reports into one bit of a primary group. The primary group also has seven sources of its own. Each group has four per-bit registers: mask, identity, enable and back queue. Every identity bit can hold two events: one visible, and one kept in its back queue. When software clears a visible bit that has a queued event, the bit sets again one clock later.

The link from the secondary group to its primary bit reacts to edges only. The secondary group's pending signal covers visible and queued events that are enabled. The primary cascade bit is set only when that signal rises. Software must therefore drain the secondary group completely, or turn its enables off and on again, before the cascade bit can set again.

All registers are reached through a simple synchronous bus. The read data is combinational on the address.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, both mask registers read 0xFF. The identity, queue and enable registers and the control register read 0x00, and `cpu_irq` is low.
- R2: A rising edge on a source whose mask bit is 0 sets that identity bit at the next clock edge. A rising edge on a masked source leaves both the identity bit and the queue bit unchanged.
- R3: An event on a bit that is already visible sets its queue bit. An event on a bit that holds both a visible and a queued event is dropped, and both bits stay 1.
- R4: Identity registers are write-one-to-clear. Writing a 0 to a bit leaves that bit unchanged.
- R5: Software may clear a visible bit whose queue bit is set. In the clock after that write, the bit reads 0 and its queue bit reads 0. In the following clock, the bit reads 1 again.
- R6: A clear and a new event may hit a bit that holds a queued event in the same clock. The bit then reads 0 for one clock and then 1, and its queue bit reads 1 from the clock after the write.
- R7: The secondary pending signal is the OR over bits of ((identity OR queue OR reload) AND enable). Primary identity bit 7 is set only by a rising edge of this signal, subject to primary mask bit 7, one clock after the edge.
- R8: While the secondary pending signal stays high, new secondary events do not set primary bit 7 again after it has been cleared.
- R9: Clearing the secondary enable register and then setting it again while secondary events are pending sets primary bit 7 again.
- R10: `cpu_irq` equals control bit 0 AND the OR over bits of (primary identity AND primary enable). Primary sources 0 to 6 map to primary bits 0 to 6.
- R11: Register addresses are as follows. 0 is the secondary identity register and 1 is the secondary queue (read-only). 2 is the secondary mask and 3 the secondary enable. 4 is the primary identity register and 5 the primary queue (read-only). 6 is the primary mask and 7 the primary enable. 8 is the control register, whose bit 0 is the master enable. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| south_src | input | 8 | Secondary group event sources, rising-edge sensitive |
| north_src | input | 7 | Primary group event sources, mapped to primary bits 0..6 |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write enable, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The assertions check on every cycle that a masked edge never creates a new visible bit, that a queue bit never stands without its visible or reloading bit, and that a reloading bit reappears one clock later. They also check that primary bit 7 rises only after a rising edge of the secondary pending signal or a reload, and that it cannot set while that signal was already high. Only the bench scenarios can show the exact register readback sequences. These include the 0-then-1 pattern after a clear with a queued event, the clear and event landing in the same clock, the enable toggle that regenerates the cascade edge, and the master gating of `cpu_irq`. The bench also checks these against a reference model under random traffic.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int SN = 8,
  parameter int NN = 8,
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SN-1:0] south_src,
  input  logic [NN-2:0] north_src,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          cpu_irq
);
  localparam int CB = NN - 1;
  localparam logic [AW-1:0] A_SID = AW'(0), A_SQ = AW'(1), A_SMK = AW'(2), A_SEN = AW'(3);
  localparam logic [AW-1:0] A_NID = AW'(4), A_NQ = AW'(5), A_NMK = AW'(6), A_NEN = AW'(7);
  localparam logic [AW-1:0] A_CTL = AW'(8);

  logic [SN-1:0] s_id, s_q, s_rl, s_mk, s_en, s_srcq, s_ev, s_clr;
  logic [SN-1:0] s_id_nx, s_q_nx, s_rl_nx;
  logic [NN-1:0] n_id, n_q, n_rl, n_mk, n_en, n_ev, n_clr;
  logic [NN-1:0] n_id_nx, n_q_nx, n_rl_nx;
  logic [NN-2:0] n_srcq;
  logic          agg_q, ctl_en, s_agg;

  // {visible, queued, reload}
  function automatic logic [2:0] slot_next(logic v, logic q, logic r, logic ev, logic clr);
    if (r)                return {1'b1, q | ev, 1'b0};
    if (v && clr && q)    return {1'b0, ev, 1'b1};
    if (v && !clr)        return {1'b1, q | ev, 1'b0};
    return {ev, 1'b0, 1'b0};
  endfunction

  assign s_agg = |((s_id | s_q | s_rl) & s_en);
  assign s_ev  = south_src & ~s_srcq & ~s_mk;
  assign n_ev  = {s_agg & ~agg_q, north_src & ~n_srcq} & ~n_mk;
  assign s_clr = (reg_we && reg_addr == A_SID) ? reg_wdata[SN-1:0] : '0;
  assign n_clr = (reg_we && reg_addr == A_NID) ? reg_wdata[NN-1:0] : '0;
  assign cpu_irq = ctl_en & |(n_id & n_en);

  always_comb begin
    for (int i = 0; i < SN; i++)
      {s_id_nx[i], s_q_nx[i], s_rl_nx[i]} = slot_next(s_id[i], s_q[i], s_rl[i], s_ev[i], s_clr[i]);
    for (int i = 0; i < NN; i++)
      {n_id_nx[i], n_q_nx[i], n_rl_nx[i]} = slot_next(n_id[i], n_q[i], n_rl[i], n_ev[i], n_clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_id <= '0; s_q <= '0; s_rl <= '0; s_mk <= '1; s_en <= '0; s_srcq <= '0;
      n_id <= '0; n_q <= '0; n_rl <= '0; n_mk <= '1; n_en <= '0; n_srcq <= '0;
      agg_q <= 1'b0; ctl_en <= 1'b0;
    end else begin
      s_id <= s_id_nx; s_q <= s_q_nx; s_rl <= s_rl_nx; s_srcq <= south_src;
      n_id <= n_id_nx; n_q <= n_q_nx; n_rl <= n_rl_nx; n_srcq <= north_src;
      agg_q <= s_agg;
      if (reg_we) begin
        case (reg_addr)
          A_SMK:   s_mk   <= reg_wdata[SN-1:0];
          A_SEN:   s_en   <= reg_wdata[SN-1:0];
          A_NMK:   n_mk   <= reg_wdata[NN-1:0];
          A_NEN:   n_en   <= reg_wdata[NN-1:0];
          A_CTL:   ctl_en <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SID:   reg_rdata = DW'(s_id);
      A_SQ:    reg_rdata = DW'(s_q);
      A_SMK:   reg_rdata = DW'(s_mk);
      A_SEN:   reg_rdata = DW'(s_en);
      A_NID:   reg_rdata = DW'(n_id);
      A_NQ:    reg_rdata = DW'(n_q);
      A_NMK:   reg_rdata = DW'(n_mk);
      A_NEN:   reg_rdata = DW'(n_en);
      A_CTL:   reg_rdata = DW'(ctl_en);
      default: reg_rdata = '0;
    endcase
  end

  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((s_id & ~$past(s_id) & $past(s_mk) & ~$past(s_q | s_rl)) == '0));

  p_queue_behind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_q & ~(s_id | s_rl)) == '0) && ((n_q & ~(n_id | n_rl)) == '0));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_rl) |=> ((s_id & $past(s_rl)) == $past(s_rl)));

  p_cascade_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(n_id[CB]) |-> (($past(s_agg) && !$past(agg_q)) || $past(n_rl[CB])));

  p_no_reedge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (agg_q && !n_id[CB] && !n_rl[CB]) |=> !n_id[CB]);
endmodule

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] SID = 0, SQ = 1, SMK = 2, SEN = 3, NID = 4, NQ = 5, NMK = 6, NEN = 7, CTL = 8;

  logic clk = 0, rst_n = 0, we = 0, irq;
  logic [7:0] ssrc = 0, wdata = 0, rdata;
  logic [6:0] nsrc = 0;
  logic [3:0] addr = 0;
  int checks = 0, errs = 0;

  cascade_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .south_src(ssrc), .north_src(nsrc),
    .reg_addr(addr), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .cpu_irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [7:0] m_sv, m_sq, m_sr, m_smk, m_sen, m_ssrcq, m_nv, m_nq, m_nr, m_nmk, m_nen;
  logic [6:0] m_nsrcq;
  logic m_aggq, m_ctl, m_agg;
  logic [7:0] t_sev, t_nev, t_sclr, t_nclr, t_sv, t_sq, t_sr, t_nv, t_nq, t_nr;

  function automatic logic [2:0] mstep(logic v, logic q, logic r, logic ev, logic clr);
    logic nv, nq, nr;
    nv = v; nq = q; nr = 1'b0;
    if (r) nv = 1'b1;
    else if (clr && v) begin nv = 1'b0; if (q) begin nr = 1'b1; nq = 1'b0; end end
    if (ev) begin if (!nv && !nr) nv = 1'b1; else nq = 1'b1; end
    return {nv, nq, nr};
  endfunction

  function automatic logic [7:0] mread(logic [3:0] a);
    case (a)
      SID: return m_sv;  SQ: return m_sq;  SMK: return m_smk; SEN: return m_sen;
      NID: return m_nv;  NQ: return m_nq;  NMK: return m_nmk; NEN: return m_nen;
      CTL: return {7'd0, m_ctl};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sv <= 0; m_sq <= 0; m_sr <= 0; m_smk <= 8'hFF; m_sen <= 0; m_ssrcq <= 0;
      m_nv <= 0; m_nq <= 0; m_nr <= 0; m_nmk <= 8'hFF; m_nen <= 0; m_nsrcq <= 0;
      m_aggq <= 0; m_ctl <= 0;
    end else begin
      m_agg  = |((m_sv | m_sq | m_sr) & m_sen);
      t_sev  = ssrc & ~m_ssrcq & ~m_smk;
      t_nev  = {m_agg & ~m_aggq, nsrc & ~m_nsrcq} & ~m_nmk;
      t_sclr = (we && addr == SID) ? wdata : 8'h00;
      t_nclr = (we && addr == NID) ? wdata : 8'h00;
      for (int i = 0; i < 8; i++) begin
        {t_sv[i], t_sq[i], t_sr[i]} = mstep(m_sv[i], m_sq[i], m_sr[i], t_sev[i], t_sclr[i]);
        {t_nv[i], t_nq[i], t_nr[i]} = mstep(m_nv[i], m_nq[i], m_nr[i], t_nev[i], t_nclr[i]);
      end
      m_sv <= t_sv; m_sq <= t_sq; m_sr <= t_sr; m_nv <= t_nv; m_nq <= t_nq; m_nr <= t_nr;
      m_ssrcq <= ssrc; m_nsrcq <= nsrc; m_aggq <= m_agg;
      if (we) case (addr)
        SMK: m_smk <= wdata; SEN: m_sen <= wdata;
        NMK: m_nmk <= wdata; NEN: m_nen <= wdata;
        CTL: m_ctl <= wdata[0];
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic peek(logic [3:0] a, logic [7:0] exp, string tag);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic pulse_s(logic [7:0] b);
    @(negedge clk); ssrc = b;
    @(negedge clk); ssrc = 0;
  endtask

  task automatic pulse_n(logic [6:0] b);
    @(negedge clk); nsrc = b;
    @(negedge clk); nsrc = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(SMK, 8'hFF, "R1 smask"); peek(NMK, 8'hFF, "R1 nmask");
    peek(SID, 0, "R1 sid"); peek(SQ, 0, "R1 sq"); peek(SEN, 0, "R1 sen");
    peek(NID, 0, "R1 nid"); peek(NQ, 0, "R1 nq"); peek(NEN, 0, "R1 nen");
    peek(CTL, 0, "R1 ctl"); chk("R1 irq", irq, 0);
    peek(4'd12, 0, "R11 unmapped");
    // R2 masked and unmasked
    pulse_s(8'h01); peek(SID, 0, "R2 masked id"); peek(SQ, 0, "R2 masked q");
    wr(SMK, 8'h00);
    pulse_s(8'h01); peek(SID, 8'h01, "R2 unmasked");
    // R3 queue and drop
    pulse_s(8'h01); peek(SQ, 8'h01, "R3 queued");
    pulse_s(8'h01); peek(SID, 8'h01, "R3 drop id"); peek(SQ, 8'h01, "R3 drop q");
    wr(SQ, 8'h00); peek(SQ, 8'h01, "R11 queue read-only");
    // R4 write zero
    wr(SID, 8'h00); peek(SID, 8'h01, "R4 zero write");
    // R5 reassert one clock later
    wr(SID, 8'h01); peek(SID, 0, "R5 gap id"); peek(SQ, 0, "R5 gap q");
    @(negedge clk); peek(SID, 8'h01, "R5 reassert"); peek(SQ, 0, "R5 consumed");
    wr(SID, 8'h01); peek(SID, 0, "R4 cleared");
    // R6 clear and event same clock
    pulse_s(8'h02); pulse_s(8'h02);
    @(negedge clk); addr = SID; we = 1; wdata = 8'h02; ssrc = 8'h02;
    @(negedge clk); we = 0; ssrc = 0;
    peek(SID, 0, "R6 gap"); peek(SQ, 8'h02, "R6 slot taken");
    @(negedge clk); peek(SID, 8'h02, "R6 reassert"); peek(SQ, 8'h02, "R6 queue kept");
    repeat (3) begin wr(SID, 8'hFF); @(negedge clk); end
    peek(SID, 0, "R4 drained id"); peek(SQ, 0, "R4 drained q");
    // R7 cascade edge
    wr(NMK, 8'h00); wr(SEN, 8'hFF);
    pulse_s(8'h04); @(negedge clk); peek(NID, 8'h80, "R7 cascade set");
    // R8 no re-edge while pending
    wr(NID, 8'h80); pulse_s(8'h08); repeat (2) @(negedge clk);
    peek(NID, 0, "R8 stays clear"); peek(SID, 8'h0C, "R8 south pending");
    // R9 enable toggle
    wr(SEN, 8'h00); wr(SEN, 8'hFF); repeat (2) @(negedge clk);
    peek(NID, 8'h80, "R9 toggle sets");
    // R10 master gating
    wr(NEN, 8'h80); #1; chk("R10 master off", irq, 0);
    wr(CTL, 8'h01); #1; chk("R10 master on", irq, 1);
    wr(NID, 8'h80); #1; chk("R10 cleared", irq, 0);
    wr(NEN, 8'h81); pulse_n(7'h01); #1; chk("R10 north src", irq, 1);
    peek(NID, 8'h01, "R10 north bit");
    // random phase against the model
    repeat (3000) begin
      @(negedge clk);
      ssrc = 8'($urandom); nsrc = 7'($urandom);
      if ($urandom % 5 == 0) begin we = 1; addr = 4'($urandom % 9); wdata = 8'($urandom); end
      else begin we = 0; addr = 4'($urandom % 10); end
      #1;
      chk("R2 random rdata", rdata, mread(addr));
      chk("R10 random irq", irq, m_ctl & |(m_nv & m_nen));
    end
    we = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule